// File: doc/BRIEF.md
# Edge-Cleared Watchdog Timer

This block watches a processor's heartbeat. Software toggles a kick line from time to time. Every change of level on that line, rising or falling, restarts an internal timer. If the kick line holds one level for a full timeout period, the active-low watchdog output drops. It stays low until something clears the timer: a new kick transition, the system reset, or the kick line floating.

A separate indication reports when the kick line is left floating, for example tri-stated. While it is set, the watchdog is disabled and the timer is held at zero. The supply-good input gates the output combinationally. During a supply fault the output is forced low. When the supply recovers, the output rises in the same cycle unless the timer has already expired.

The timeout is a parameter in clock cycles. Its default covers 1.6 s at 200 MHz, and a bench can shorten it for simulation.

Top module: `wdt_edge_guard`

## Requirements
- R1: While reset is active, and in the first cycles after it is released, the timer reads zero and `wdo_n_o` equals `supply_ok_i`.
- R2: With no clearing event and the supply good, `wdo_n_o` goes low exactly `TIMEOUT_CYC` clock cycles after the timer was last cleared, and not earlier.
- R3: A rising or a falling transition of `kick_i` clears the timer. The input passes `SYNC_STAGES` (default 2) synchroniser flops and then a compare flop, so with the default the timer reads zero after the third rising clock edge following the change.
- R4: After a timeout the timer saturates at `TIMEOUT_CYC` and never wraps. `wdo_n_o` stays low, through any number of cycles and through a supply dip and recovery, until the timer is cleared.
- R5: A kick transition that arrives while `wdo_n_o` is low, after a timeout, returns the output high on the clock after the transition is detected.
- R6: `sys_rst_i` high at a rising clock edge clears the timer at that edge, and this applies after a timeout as well.
- R7: While `kick_float_i` is high, the timer is held at zero and the output never times out. Once it drops, a full `TIMEOUT_CYC` count starts from zero.
- R8: While `supply_ok_i` is low, `wdo_n_o` is low in that same cycle, whatever the timer holds.
- R9: When `supply_ok_i` returns high and the timer has not expired, `wdo_n_o` is high in that same cycle, with no hold period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| kick_i | input | 1 | Watchdog kick; any level change restarts the timer |
| kick_float_i | input | 1 | High when the kick line is floating; disables the watchdog |
| supply_ok_i | input | 1 | High when the supply is above its threshold |
| sys_rst_i | input | 1 | High while the system reset is asserted; clears the timer |
| wdo_n_o | output | 1 | Active-low watchdog output |

## Verification
The bench checks the exact cycle of the timeout. A design that is off by one would drop the output a cycle early or a cycle late. The output is then held low for more than twice the counter range. A counter that wraps instead of saturating would release the output on its own during that stretch.

Both edge polarities are exercised through the synchroniser, so a detector that only sees one polarity would let the output time out. The bench also floats the kick line for a long stretch, which catches a timer that keeps counting while it should be disabled. A supply dip is applied both before and after a timeout. A registered supply gate would answer one cycle late, and a recovery that cleared the timer would raise an expired output.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Causes that restart the watchdog timer.
  typedef struct packed {
    logic sys_rst;
    logic kick_edge;
    logic floating;
  } wdt_clr_t;

  function automatic logic clr_any(input wdt_clr_t c);
    return c.sys_rst | c.kick_edge | c.floating;
  endfunction

endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] rs_q;
  logic [STAGES-1:0] rs_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb rs_d = 1'b1;
    end else begin : g_chain
      always_comb rs_d = {rs_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= rs_d;
  end

  assign rst_n_o = rs_q[STAGES-1];

endmodule

// File: rtl/wdt_kick_sync.sv
module wdt_kick_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_i,
  output logic kick_edge_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   last_q;
  logic                   last_d;

  generate
    if (SYNC_STAGES == 1) begin : g_one_stage
      always_comb sync_d = kick_i;
    end else begin : g_multi_stage
      always_comb sync_d = {sync_q[SYNC_STAGES-2:0], kick_i};
    end
  endgenerate

  always_comb last_d = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  // Either polarity of change counts as a kick.
  assign kick_edge_o = sync_q[SYNC_STAGES-1] ^ last_q;

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int TIMEOUT_CYC = 320_000_000,
  parameter int CNT_W       = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wdt_clr_t         clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expired_o
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             clear;
  logic             at_limit;

  always_comb begin
    clear    = clr_any(clr_i);
    at_limit = (cnt_q == LIMIT);
    cnt_en   = clear | ~at_limit;   // hold once saturated
    cnt_d    = clear ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o     = cnt_q;
  assign expired_o = at_limit;

endmodule

// File: rtl/wdt_edge_guard.sv
module wdt_edge_guard
  import wdt_pkg::*;
#(
  parameter int TIMEOUT_CYC = 320_000_000,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_i,
  input  logic kick_float_i,
  input  logic supply_ok_i,
  input  logic sys_rst_i,
  output logic wdo_n_o
);

  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);

  logic             rst_sync_n;
  logic             kick_edge;
  logic [CNT_W-1:0] tmr_cnt;
  logic             tmr_expired;
  wdt_clr_t         tmr_clr;

  wdt_rst_sync #(
    .STAGES (RST_STAGES)
  ) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_sync_n)
  );

  wdt_kick_sync #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_kick_sync (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .kick_i      (kick_i),
    .kick_edge_o (kick_edge)
  );

  always_comb begin
    tmr_clr.sys_rst   = sys_rst_i;
    tmr_clr.kick_edge = kick_edge;
    tmr_clr.floating  = kick_float_i;
  end

  wdt_timer #(
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .CNT_W       (CNT_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clr_i     (tmr_clr),
    .cnt_o     (tmr_cnt),
    .expired_o (tmr_expired)
  );

  // Supply gate is combinational so recovery is seen at once.
  assign wdo_n_o = supply_ok_i & ~tmr_expired;

endmodule

// File: rtl/wdt_edge_guard_chk.sv
module wdt_edge_guard_chk #(
  parameter int TIMEOUT_CYC = 320_000_000,
  parameter int CNT_W       = $clog2(TIMEOUT_CYC + 1)
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             kick_float_i,
  input logic             supply_ok_i,
  input logic             sys_rst_i,
  input logic             kick_edge,
  input logic [CNT_W-1:0] tmr_cnt,
  input logic             wdo_n_o
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYC);

  logic no_clr;
  assign no_clr = !sys_rst_i && !kick_edge && !kick_float_i;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tmr_cnt <= LIMIT); // R4

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tmr_cnt == LIMIT) && no_clr |=> tmr_cnt == LIMIT); // R4

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tmr_cnt != LIMIT) && no_clr |=> tmr_cnt == $past(tmr_cnt) + 1'b1); // R2

  AST_EDGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    kick_edge |=> tmr_cnt == '0); // R3

  AST_SYSRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sys_rst_i |=> tmr_cnt == '0); // R6

  AST_FLOAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    kick_float_i |=> tmr_cnt == '0); // R7

  AST_SUPPLY_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !supply_ok_i |-> !wdo_n_o); // R8

  AST_RECOVER_HIGH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    supply_ok_i && (tmr_cnt != LIMIT) |-> wdo_n_o); // R9

endmodule

bind wdt_edge_guard wdt_edge_guard_chk #(
  .TIMEOUT_CYC (TIMEOUT_CYC)
) u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .kick_float_i (kick_float_i),
  .supply_ok_i  (supply_ok_i),
  .sys_rst_i    (sys_rst_i),
  .kick_edge    (kick_edge),
  .tmr_cnt      (tmr_cnt),
  .wdo_n_o      (wdo_n_o)
);

// File: tb/wdt_edge_guard_bench.sv
`timescale 1ns/1ps
module wdt_edge_guard_bench;

  localparam int T = 8;

  logic clk;
  logic rst_n;
  logic kick;
  logic flt;
  logic sup;
  logic srst;
  logic wdo_n;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  item_t q[$];
  int    n_chk;
  int    n_fail;
  bit    done;

  wdt_edge_guard #(
    .TIMEOUT_CYC (T)
  ) u_wdt_edge_guard (
    .clk          (clk),
    .rst_n        (rst_n),
    .kick_i       (kick),
    .kick_float_i (flt),
    .supply_ok_i  (sup),
    .sys_rst_i    (srst),
    .wdo_n_o      (wdo_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Driver: one call per clock, expected output for this cycle queued.
  task automatic drv(input logic kk, input logic ff, input logic ss,
                     input logic rr, input logic exp, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    kick = kk; flt = ff; sup = ss; srst = rr;
    it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic run(input int n, input logic kk, input logic ff, input logic ss,
                     input logic rr, input logic exp, input string tag);
    for (int i = 0; i < n; i++) drv(kk, ff, ss, rr, exp, tag);
  endtask

  // Monitor: compares at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_chk++;
        if (wdo_n !== it.exp) begin
          n_fail++;
          $display("FAIL %s: wdo_n_o=%b expected %b at %0t", it.tag, wdo_n, it.exp, $time);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; kick = 1'b0; flt = 1'b0; sup = 1'b1; srst = 1'b0;

    // R1 reset state
    run(3, 0, 0, 1, 0, 1'b1, "R1");
    rst_n = 1'b1;
    drv(0, 0, 1, 1, 1'b1, "R1");

    // R2 exact timeout, R4 saturation well past counter range
    run(T, 0, 0, 1, 0, 1'b1, "R2");
    drv(0, 0, 1, 0, 1'b0, "R2");
    run(40, 0, 0, 1, 0, 1'b0, "R4");

    // R5 rising kick while low, R3 rising edge restarts full count
    drv(1, 0, 1, 0, 1'b0, "R5");
    run(2, 1, 0, 1, 0, 1'b0, "R5");
    drv(1, 0, 1, 0, 1'b1, "R5");
    run(T - 1, 1, 0, 1, 0, 1'b1, "R3");
    drv(1, 0, 1, 0, 1'b0, "R3");

    // R3 falling edge
    drv(0, 0, 1, 0, 1'b0, "R3");
    run(2, 0, 0, 1, 0, 1'b0, "R3");
    drv(0, 0, 1, 0, 1'b1, "R3");

    // R3 periodic kicks of both polarities keep it alive
    for (int i = 0; i < 8; i++) begin
      logic kv;
      kv = (i % 2 == 0);
      drv(kv, 0, 1, 0, 1'b1, "R3");
      run(3, kv, 0, 1, 0, 1'b1, "R3");
    end

    // R6 system reset restarts, also after a timeout
    drv(0, 0, 1, 1, 1'b1, "R6");
    run(T, 0, 0, 1, 0, 1'b1, "R6");
    drv(0, 0, 1, 0, 1'b0, "R2");
    drv(0, 0, 1, 1, 1'b0, "R6");
    drv(0, 0, 1, 0, 1'b1, "R6");

    // R7 floating input disables, then full count from zero
    drv(0, 1, 1, 0, 1'b1, "R7");
    run(30, 0, 1, 1, 0, 1'b1, "R7");
    drv(0, 0, 1, 0, 1'b1, "R7");
    run(T - 1, 0, 0, 1, 0, 1'b1, "R7");
    drv(0, 0, 1, 0, 1'b0, "R7");
    drv(0, 1, 1, 0, 1'b0, "R7");
    drv(0, 1, 1, 0, 1'b1, "R7");
    drv(0, 0, 1, 0, 1'b1, "R7");

    // R8 supply dip forces low, R9 recovery is immediate
    drv(0, 0, 1, 1, 1'b1, "R6");
    drv(0, 0, 0, 0, 1'b0, "R8");
    drv(0, 0, 0, 0, 1'b0, "R8");
    drv(0, 0, 1, 0, 1'b1, "R9");
    run(5, 0, 0, 1, 0, 1'b1, "R9");
    drv(0, 0, 1, 0, 1'b0, "R2");
    drv(0, 0, 0, 0, 1'b0, "R8");
    run(3, 0, 0, 1, 0, 1'b0, "R4");

    @(negedge clk);
    #1;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule